// File: doc/BRIEF.md
# Reset Sequencer and Strap Shadow for a PHY Management Register File

This block sits in front of a small PHY management register file and decides what its configuration registers hold after each of two kinds of reset. While the hardware reset pin is held low, the configuration straps (auto-negotiation enable, speed, duplex and a set of advertised abilities) are copied every clock into a shadow register. The live registers are loaded from the same straps. After the pin is released, the register port stays closed for 1 ms, counted as 1000 pulses of a 1 µs tick. Reads during that time return zero and raise a not-ready flag, and writes are dropped.

Software starts the second kind of reset by writing 1 to bit 15 of the control register. This software reset runs for a fixed number of clocks. It restores the control and advertisement fields from the shadow copy and never samples the pins again. The general configuration register returns to its reset value. During a software reset the registers can still be read, and bit 15 reads 1 until the reset ends, so software can poll it. A hardware reset always wins over a software reset that is still running.

Top module: `phy_rst_cfg_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the straps are sampled. After release, the control register (address 0) shows the strap values from the last low edge: strap bit 6 (auto-negotiation enable) at bit 12, strap bit 5 (speed) at bit 13 and strap bit 4 (duplex) at bit 8. The advertisement register (address 4) shows strap bits 3:0 at bits 8:5.
- R2: `reg_ready_o` is low during reset and stays low after release until 1000 ticks have been counted. It goes high right after the clock edge that counts the 1000th tick.
- R3: While `reg_ready_o` is low, `rdata_o` is zero, `rd_nrdy_o` follows `rd_en`, and writes leave every register unchanged.
- R4: Changes on the strap pins after reset is released have no effect on any register, either directly or through a later software reset.
- R5: When the port is ready and no software reset is running, a write to address 0 with bit 15 set starts a software reset. `sw_busy_o` is then high for exactly 16 clocks, and bit 15 of the control register reads 1 during that time and 0 afterwards.
- R6: A software reset reloads the control and advertisement fields from the shadow copy and sets the configuration register (address 16) to its reset value, 16'h0C04.
- R7: During a software reset, reads return the current register contents and writes are ignored.
- R8: When the port is ready and idle, writes store only these fields: control bits 13, 12 and 8; advertisement bits 8:5; and all 16 bits of the configuration register. Unused bits and unmapped addresses read zero.
- R9: Pulling `rst_n` low during a software reset aborts it (`sw_busy_o` is low after release) and restarts the full hardware sequence, including the strap capture and the 1 ms blackout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset pin, synchronous, active low |
| strap_i | input | 7 | Configuration straps {an_en, speed, duplex, abilities[3:0]} |
| tick_us | input | 1 | One-cycle pulse every 1 µs |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| addr | input | 5 | Register address |
| wdata | input | 16 | Write data |
| rdata_o | output | 16 | Read data (combinational from addr) |
| rd_nrdy_o | output | 1 | Read attempted while the port is closed |
| reg_ready_o | output | 1 | Register port open (blackout over) |
| sw_busy_o | output | 1 | Software reset in progress |

## Verification
If the shadow copy is wrong, nothing shows at the ports until the end of the next software reset. The reloaded control and advertisement values then differ from the straps captured at release, so the bench sets the pins to a different pattern before starting a software reset. An off-by-one error in the blackout counter moves `reg_ready_o` by one tick, which the bench detects by checking after tick 999 and again after tick 1000. An error in the software-reset counter moves the fall of `sw_busy_o` by one or more clocks, and the bench checks every cycle of that window.

// File: rtl/rstcfg_pkg.sv
// Package: shared strap layout and register addresses for the reset
// sequencer. Assumes a 5-bit register address and 16-bit registers.
package rstcfg_pkg;
    localparam int ADV_W   = 4;
    localparam int STRAP_W = 3 + ADV_W;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 5;

    localparam logic [ADDR_W-1:0] A_CTRL = 5'd0;
    localparam logic [ADDR_W-1:0] A_ADV  = 5'd4;
    localparam logic [ADDR_W-1:0] A_CFG  = 5'd16;

    // control register bit positions
    localparam int B_RST    = 15;
    localparam int B_SPEED  = 13;
    localparam int B_AN     = 12;
    localparam int B_DUPLEX = 8;
    localparam int ADV_LSB  = 5;

    typedef struct packed {
        logic             an_en;
        logic             speed;
        logic             duplex;
        logic [ADV_W-1:0] adv;
    } strap_t;
endpackage

// File: rtl/rstcfg_blackout.sv
// Module: counts microsecond ticks after the hardware reset pin is
// released and opens the register port once TICKS have been seen.
// Assumes tick_us is a single-cycle pulse synchronous to clk.
module rstcfg_blackout #(
    parameter int TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_us,
    output logic ready_o
);
    localparam int CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TICKS);

    logic [CW-1:0] cnt_q;

    // count ticks up to the limit, then hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick_us && cnt_q != LIMIT)
            cnt_q <= cnt_q + 1'b1;
    end

    assign ready_o = (cnt_q == LIMIT);

    p_ready_after_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(tick_us));
    p_ready_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o);
endmodule

// File: rtl/rstcfg_swrst_seq.sv
// Module: times a software reset of fixed length. A start pulse loads
// the down-counter; busy stays high for exactly CYCLES clocks.
// Assumes start is only raised while idle; the hardware reset aborts.
module rstcfg_swrst_seq #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ready_i,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    // load on start, count down, drop busy after the last cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start_i && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= LOAD;
        end else if (busy_q) begin
            if (cnt_q == '0)
                busy_q <= 1'b0;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy_o = busy_q;

    p_start_when_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(ready_i));
endmodule

// File: rtl/rstcfg_regfile.sv
// Module: holds the strap shadow and the configuration registers.
// The shadow is written only while the hardware reset pin is low; the
// live fields reload from it when a software reset starts.
// Assumes wr_ok_i is already gated by readiness and idleness.
module rstcfg_regfile
    import rstcfg_pkg::*;
#(
    parameter logic [DATA_W-1:0] CFG_RST = 16'h0C04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  strap_t            strap_i,
    input  logic              wr_ok_i,
    input  logic              sw_start_i,
    input  logic              sw_busy_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    strap_t            shadow_q;
    strap_t            live_q;
    logic [DATA_W-1:0] cfg_q;

    // shadow copy follows the pins only during hardware reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= strap_i;
    end

    // live registers: reset from pins, reload from shadow, or write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= strap_i;
            cfg_q  <= CFG_RST;
        end else if (sw_start_i) begin
            live_q <= shadow_q;
            cfg_q  <= CFG_RST;
        end else if (wr_ok_i) begin
            if (addr_i == A_CTRL) begin
                live_q.an_en  <= wdata_i[B_AN];
                live_q.speed  <= wdata_i[B_SPEED];
                live_q.duplex <= wdata_i[B_DUPLEX];
            end
            if (addr_i == A_ADV)
                live_q.adv <= wdata_i[ADV_LSB +: ADV_W];
            if (addr_i == A_CFG)
                cfg_q <= wdata_i;
        end
    end

    // read multiplexer
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CTRL: begin
                rdata_o[B_RST]    = sw_busy_i;
                rdata_o[B_SPEED]  = live_q.speed;
                rdata_o[B_AN]     = live_q.an_en;
                rdata_o[B_DUPLEX] = live_q.duplex;
            end
            A_ADV:   rdata_o[ADV_LSB +: ADV_W] = live_q.adv;
            A_CFG:   rdata_o = cfg_q;
            default: rdata_o = '0;
        endcase
    end

    p_shadow_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(shadow_q));
    p_cfg_held_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sw_busy_i |=> $stable(cfg_q) && $stable(live_q));
endmodule

// File: rtl/phy_rst_cfg_ctrl.sv
// Module: top of the reset sequencer. Gates the register port with
// the post-reset blackout, decodes the software-reset request and
// drops writes while either reset is in progress.
// Assumes rst_n is already synchronous to clk.
module phy_rst_cfg_ctrl
    import rstcfg_pkg::*;
#(
    parameter int                TICKS   = 1000,
    parameter int                SW_CYC  = 16,
    parameter logic [DATA_W-1:0] CFG_RST = 16'h0C04
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               tick_us,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               rd_nrdy_o,
    output logic               reg_ready_o,
    output logic               sw_busy_o
);
    logic              ready;
    logic              busy;
    logic              wr_ok;
    logic              sw_start;
    logic [DATA_W-1:0] raw_rdata;
    strap_t            straps;

    assign straps   = strap_t'(strap_i);
    assign wr_ok    = wr_en && ready && !busy;
    assign sw_start = wr_ok && (addr == A_CTRL) && wdata[B_RST];

    rstcfg_blackout #(.TICKS(TICKS)) u_blackout (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_us (tick_us),
        .ready_o (ready)
    );

    rstcfg_swrst_seq #(.CYCLES(SW_CYC)) u_swrst (
        .clk     (clk),
        .rst_n   (rst_n),
        .ready_i (ready),
        .start_i (sw_start),
        .busy_o  (busy)
    );

    rstcfg_regfile #(.CFG_RST(CFG_RST)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_i    (straps),
        .wr_ok_i    (wr_ok),
        .sw_start_i (sw_start),
        .sw_busy_i  (busy),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .rdata_o    (raw_rdata)
    );

    assign rdata_o     = ready ? raw_rdata : '0;
    assign rd_nrdy_o   = rd_en && !ready;
    assign reg_ready_o = ready;
    assign sw_busy_o   = busy;

    p_nrdy_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_nrdy_o |-> (rdata_o == '0));
    p_busy_needs_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_busy_o |-> reg_ready_o);
endmodule

// File: tb/phy_rst_cfg_ctrl_tb.sv
module phy_rst_cfg_ctrl_tb;
    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] CFG_RST    = 16'h0C04;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  strap = '0;
    logic        tick = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rd_nrdy;
    logic        ready;
    logic        busy;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_rst_cfg_ctrl #(.TICKS(1000), .SW_CYC(16), .CFG_RST(CFG_RST)) u_dut (
        .clk(clk), .rst_n(rst_n), .strap_i(strap), .tick_us(tick),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata_o(rdata), .rd_nrdy_o(rd_nrdy), .reg_ready_o(ready),
        .sw_busy_o(busy)
    );

    // write/read walk: {addr, write data, expected read}
    typedef struct packed {
        logic [4:0]  a;
        logic [15:0] w;
        logic [15:0] e;
    } vec_t;
    localparam vec_t VECS [8] = '{
        '{5'd16, 16'hABCD, 16'hABCD},
        '{5'd0,  16'h3100, 16'h3100},
        '{5'd0,  16'h7FFF, 16'h3100},
        '{5'd0,  16'h0000, 16'h0000},
        '{5'd4,  16'hFFFF, 16'h01E0},
        '{5'd4,  16'h0020, 16'h0020},
        '{5'd5,  16'h1234, 16'h0000},
        '{5'd16, 16'h0000, 16'h0000}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
        #1;
    endtask

    task automatic hw_reset(input logic [6:0] s);
        @(negedge clk);
        rst_n = 1'b0; strap = 7'h7F;
        repeat (2) @(negedge clk);
        strap = s;
        @(negedge clk);
        rst_n = 1'b1;
        strap = ~s;  // pins change right after release
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++; total++;
        $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        // reset state
        repeat (2) @(negedge clk);
        #1 check("R2 ready in reset", {15'b0, ready}, 16'h0);
        check("R5 busy in reset", {15'b0, busy}, 16'h0);

        // S1: an=1 speed=1 duplex=0 adv=0101
        hw_reset(7'b110_0101);
        check("R2 ready after release", {15'b0, ready}, 16'h0);
        rd(5'd16, v);
        check("R3 read zero in blackout", v, 16'h0);
        rd_en = 1'b1; #1;
        check("R3 nrdy flag", {15'b0, rd_nrdy}, 16'h1);
        rd_en = 1'b0;
        wr(5'd16, 16'h1111);
        ticks(999);
        check("R2 not ready after 999 ticks", {15'b0, ready}, 16'h0);
        ticks(1);
        check("R2 ready after 1000 ticks", {15'b0, ready}, 16'h1);
        rd(5'd16, v);
        check("R3 blackout write dropped", v, CFG_RST);
        rd(5'd0, v);
        check("R1 ctrl from straps", v, 16'h3000);
        rd(5'd4, v);
        check("R1 adv from straps", v, 16'h00A0);
        rd(5'd0, v);
        check("R4 pins after release ignored", v, 16'h3000);

        // R8 vector walk
        foreach (VECS[i]) begin
            wr(VECS[i].a, VECS[i].w);
            rd(VECS[i].a, v);
            check($sformatf("R8 vec %0d", i), v, VECS[i].e);
        end

        // software reset, pins now differ from shadow
        wr(5'd16, 16'h5A5A);
        wr(5'd0, 16'h0000);
        strap = 7'b000_1010;
        wr(5'd0, 16'h8000);
        for (int i = 0; i < 16; i++) begin
            if (i == 4) wr_en = 1'b0;
            #1 check($sformatf("R5 busy cycle %0d", i), {15'b0, busy}, 16'h1);
            rd(5'd0, v);
            check("R5 bit15 reads 1", v, 16'hB000);
            rd(5'd16, v);
            check("R7 readable during reset", v, CFG_RST);
            if (i == 3) begin wr_en = 1'b1; addr = 5'd16; wdata = 16'hFFFF; end
            @(negedge clk);
        end
        wr_en = 1'b0;
        #1 check("R5 busy ends after 16", {15'b0, busy}, 16'h0);
        rd(5'd0, v);
        check("R6 ctrl reloaded from shadow (R4)", v, 16'h3000);
        rd(5'd4, v);
        check("R6 adv reloaded", v, 16'h00A0);
        rd(5'd16, v);
        check("R7 write during reset ignored", v, CFG_RST);

        // hardware reset in the middle of a software reset
        wr(5'd0, 16'h8000);
        repeat (5) @(negedge clk);
        #1 check("R9 busy before abort", {15'b0, busy}, 16'h1);
        hw_reset(7'b001_0011);
        check("R9 busy cleared", {15'b0, busy}, 16'h0);
        check("R9 blackout restarted", {15'b0, ready}, 16'h0);
        ticks(1000);
        check("R9 ready again", {15'b0, ready}, 16'h1);
        rd(5'd0, v);
        check("R9 ctrl new straps", v, 16'h0100);
        rd(5'd4, v);
        check("R9 adv new straps", v, 16'h0060);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule